// File: doc/BRIEF.md
# Framed AFSK Tone Modulator

This block is the transmit side of an audio frequency-shift keyed link. It takes bytes from an external byte FIFO and wraps them in runs of flag bytes before and after the data. It applies zero-bit stuffing and NRZI line coding. The result is a stream of 8-bit unsigned sine samples, one for each sample-rate tick. The tone is one of two frequencies: a low "mark" tone and a high "space" tone. A zero bit swaps the tone and a one bit keeps it. The samples come from a 9-bit phase accumulator, which addresses a quarter-wave table that is built at elaboration.

Software or a host engine fills the FIFO and then pulses `start`, with a preamble flag count and a trailer flag count. The block raises `busy` and pulls bytes as the bit timing needs them. When the FIFO is empty and the trailer count has run out, the block returns to idle and parks the output at midscale (128). A byte equal to the escape code 0x1B is not sent. Instead, the byte that follows it is sent as plain data, with stuffing applied, whatever its value.

`sample_tick` is a one-cycle strobe that must be at least two clock cycles apart from the previous strobe. Each tick's sample appears on `sample` after the second rising clock edge that follows the tick.

Top module: `afsk_hdlc_modulator`

## Requirements
- R1: After reset and while idle: `busy` is 0, `sample` is 128 and `fifo_pop` is 0.
- R2: A `start` pulse while idle raises `busy` at the next edge. It loads both counts, selects the mark tone and clears the phase to 0. `sample` stays unchanged until the first tick.
- R3: On each active tick the phase advances by 64 (mark) or 117 (space), modulo 512. `sample` then shows the table value at the new phase, two clock edges after the tick.
- R4: For a phase p, let h = p mod 256 and i = h when h < 128, otherwise 255 − h. The quarter entry is q(i) = 128 + floor(2032·m / (1310720 − 4·m)), with m = (2i+1)(511−2i). The sample is q(i) for p < 256 and 255 − q(i) otherwise.
- R5: Every bit lasts 8 ticks, and the bits of a byte go out least-significant first.
- R6: A zero bit toggles the tone and clears the count of consecutive ones. A one bit keeps the tone and increments that count.
- R7: In stuffed bytes, after five ones an extra tone toggle takes one bit slot. This slot consumes no data bit and clears the count.
- R8: Bytes 0x7E (flag) and 0x7F (abort) go out unstuffed. The ones count is cleared at the start of a byte whenever the previous byte was unstuffed.
- R9: The preamble count of 0x7E flags goes out first, then the FIFO data, then trailer-count flags. At the next byte boundary after that, with the FIFO empty and the trailer count at zero, `busy` falls and `sample` returns to 128.
- R10: After a fetched 0x1B, the next FIFO byte is sent stuffed and literally. If the FIFO is empty at that moment, transmission stops at once.
- R11: A `start` pulse while busy only reloads the trailer count.
- R12: `fifo_pop` is asserted only when the FIFO is not empty, and exactly once per byte taken.
- R13: Ticks while idle change neither `sample` nor the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe at the sample rate |
| start | input | 1 | Begin a frame, or reload the trailer count when busy |
| preamble_len | input | PRE_W | Number of leading flag bytes |
| trailer_len | input | TRL_W | Number of trailing flag bytes |
| fifo_empty | input | 1 | Byte FIFO has no data |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Take the head byte this cycle |
| busy | output | 1 | Frame in progress |
| sample | output | 8 | Unsigned sine sample |

## Verification
A wrong phase value appears in the very next sample. A wrong ones count or a wrong stuffing flag appears within one bit time, 8 ticks, as a tone toggle placed in the wrong slot. After that point, every later sample differs from the model. Miscounted preamble or trailer flags move the fall of `busy` by a whole byte time of 64 ticks. A bad escape or pop decision shows at once as a mismatch between FIFO depth and the model, and as a changed bit pattern within the next byte.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  localparam int unsigned PHASE_W  = 9;
  localparam int unsigned TABLE_LEN = 1 << PHASE_W;
  localparam int unsigned QLEN     = TABLE_LEN / 4;

  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'h7F;
  localparam logic [7:0] ESC_BYTE   = 8'h1B;
  localparam logic [7:0] MID_LEVEL  = 8'd128;

  // rounded table steps per sample for a given tone
  function automatic int unsigned tone_step(int unsigned tone_hz, int unsigned rate_hz);
    return (TABLE_LEN * tone_hz + rate_hz / 2) / rate_hz;
  endfunction

  // quarter-wave entry from a rational sine approximation
  function automatic logic [7:0] quarter_entry(int unsigned i);
    int unsigned m;
    m = (2 * i + 1) * (511 - 2 * i);
    return 8'(32'd128 + (32'd2032 * m) / (32'd1310720 - 32'd4 * m));
  endfunction

  function automatic logic [QLEN*8-1:0] build_quarter();
    logic [QLEN*8-1:0] t;
    t = '0;
    for (int unsigned i = 0; i < QLEN; i++) begin
      t[i*8 +: 8] = quarter_entry(i);
    end
    return t;
  endfunction

  function automatic logic sent_unstuffed(logic [7:0] b);
    return (b == FLAG_BYTE) || (b == ABORT_BYTE);
  endfunction

endpackage

// File: rtl/afsk_sine_lut.sv
module afsk_sine_lut
  import afsk_pkg::*;
(
  input  logic [PHASE_W-1:0] phase,
  output logic [7:0]         level
);

  localparam logic [QLEN*8-1:0] QTAB = build_quarter();
  localparam int unsigned QW = PHASE_W - 2;

  logic [PHASE_W-2:0] half_pos;
  logic [QW-1:0]      qidx;
  logic [7:0]         qval;

  always_comb begin
    half_pos = phase[PHASE_W-2:0];
    // second quarter reads the table backwards
    qidx     = half_pos[PHASE_W-2] ? ~half_pos[QW-1:0] : half_pos[QW-1:0];
    qval     = QTAB[qidx*8 +: 8];
    level    = phase[PHASE_W-1] ? (8'd255 - qval) : qval;
  end

endmodule

// File: rtl/afsk_byte_framer.sv
module afsk_byte_framer
  import afsk_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned TRL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [PRE_W-1:0] pre_in,
  input  logic [TRL_W-1:0] trl_in,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  input  logic             need_byte,
  output logic             busy,
  output logic             start_idle,
  output logic             fifo_pop,
  output logic             load,
  output logic             clr_ones,
  output logic             step,
  output logic             stop,
  output logic             stuff_en,
  output logic [7:0]       byte_now
);

  logic             busy_q, stuff_q, esc_q, stage_b_q;
  logic [PRE_W-1:0] pre_q;
  logic [TRL_W-1:0] trl_q;
  logic [7:0]       cur_q;

  logic go_a, fetch, drained, stop_a, stop_b, esc_b;
  logic pre_flag, trl_flag, pop_a, pop_b;
  logic [7:0] new_byte;

  always_comb begin
    start_idle = start && !busy_q;
    go_a       = tick && busy_q;
    fetch      = go_a && need_byte;
    drained    = fifo_empty && (trl_q == '0);
    stop_a     = fetch && drained;
    pre_flag   = (pre_q != '0);
    trl_flag   = !pre_flag && fifo_empty;
    load       = fetch && !drained;
    pop_a      = load && !pre_flag && !fifo_empty;
    new_byte   = (pre_flag || trl_flag) ? FLAG_BYTE : fifo_data;
    clr_ones   = load && !stuff_q;
    esc_b      = stage_b_q && esc_q;
    stop_b     = esc_b && fifo_empty;
    pop_b      = esc_b && !fifo_empty;
    step       = stage_b_q && !stop_b;
    stop       = stop_a || stop_b;
    fifo_pop   = pop_a || pop_b;
    byte_now   = esc_q ? fifo_data : cur_q;
    busy       = busy_q;
    stuff_en   = stuff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      stuff_q   <= 1'b0;
      esc_q     <= 1'b0;
      stage_b_q <= 1'b0;
      pre_q     <= '0;
      trl_q     <= '0;
      cur_q     <= '0;
    end else if (start_idle) begin
      busy_q    <= 1'b1;
      stuff_q   <= 1'b0;
      esc_q     <= 1'b0;
      stage_b_q <= 1'b0;
      pre_q     <= pre_in;
      trl_q     <= trl_in;
    end else begin
      stage_b_q <= go_a && !stop_a;
      if (load) begin
        cur_q   <= new_byte;
        stuff_q <= !sent_unstuffed(new_byte);
        esc_q   <= (new_byte == ESC_BYTE);
        if (pre_flag)      pre_q <= pre_q - PRE_W'(1);
        else if (trl_flag) trl_q <= trl_q - TRL_W'(1);
      end
      if (esc_b) begin
        esc_q <= 1'b0;
        cur_q <= fifo_data;
      end
      if (start) trl_q <= trl_in;
      if (stop)  busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/afsk_line_coder.sv
module afsk_line_coder
  import afsk_pkg::*;
#(
  parameter int unsigned SPB        = 8,
  parameter logic [PHASE_W-1:0] MARK_STEP  = 9'd64,
  parameter logic [PHASE_W-1:0] SPACE_STEP = 9'd117
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_idle,
  input  logic               load,
  input  logic               clr_ones,
  input  logic               step,
  input  logic               stop,
  input  logic               stuff_en,
  input  logic [7:0]         byte_now,
  input  logic [7:0]         level,
  output logic               need_byte,
  output logic [PHASE_W-1:0] phase_nx,
  output logic [PHASE_W-1:0] phase,
  output logic [2:0]         ones,
  output logic               tone_space,
  output logic [7:0]         sample
);

  localparam int unsigned CNT_W = (SPB > 1) ? $clog2(SPB) : 1;
  localparam logic [2:0]  RUN_MAX = 3'd5;

  logic [3:0]         idx_q;
  logic [2:0]         ones_q;
  logic               space_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PHASE_W-1:0] phase_q;
  logic [7:0]         sample_q;

  logic bit_time, stuff_slot, cur_bit, toggle, space_nx;

  always_comb begin
    bit_time   = (cnt_q == '0);
    stuff_slot = stuff_en && (ones_q >= RUN_MAX);
    cur_bit    = byte_now[idx_q[2:0]];
    toggle     = step && bit_time && (stuff_slot || !cur_bit);
    space_nx   = space_q ^ toggle;
    phase_nx   = phase_q + (space_nx ? SPACE_STEP : MARK_STEP);
    need_byte  = bit_time && idx_q[3];
    phase      = phase_q;
    ones       = ones_q;
    tone_space = space_q;
    sample     = sample_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= 4'd8;
      ones_q   <= '0;
      space_q  <= 1'b0;
      cnt_q    <= '0;
      phase_q  <= '0;
      sample_q <= MID_LEVEL;
    end else if (start_idle) begin
      idx_q   <= 4'd8;
      ones_q  <= '0;
      space_q <= 1'b0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      if (load) begin
        idx_q <= 4'd0;
        if (clr_ones) ones_q <= '0;
      end
      if (step) begin
        space_q  <= space_nx;
        phase_q  <= phase_nx;
        sample_q <= level;
        if (bit_time) begin
          cnt_q <= CNT_W'(SPB - 1);
          if (stuff_slot) begin
            ones_q <= '0;
          end else begin
            idx_q  <= idx_q + 4'd1;
            if (!cur_bit)            ones_q <= '0;
            else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (stop) sample_q <= MID_LEVEL;
    end
  end

endmodule

// File: rtl/afsk_hdlc_modulator.sv
module afsk_hdlc_modulator
  import afsk_pkg::*;
#(
  parameter int unsigned SAMPLE_HZ = 9600,
  parameter int unsigned BIT_HZ    = 1200,
  parameter int unsigned MARK_HZ   = 1200,
  parameter int unsigned SPACE_HZ  = 2200,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned TRL_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             start,
  input  logic [PRE_W-1:0] preamble_len,
  input  logic [TRL_W-1:0] trailer_len,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             busy,
  output logic [7:0]       sample
);

  localparam int unsigned SPB = SAMPLE_HZ / BIT_HZ;
  localparam logic [PHASE_W-1:0] MARK_STEP  = PHASE_W'(tone_step(MARK_HZ, SAMPLE_HZ));
  localparam logic [PHASE_W-1:0] SPACE_STEP = PHASE_W'(tone_step(SPACE_HZ, SAMPLE_HZ));

  // named internal events, also watched by the checker
  logic               start_idle_w, load_w, clr_w, step_w, stop_w, stuff_w, need_w;
  logic               space_w;
  logic [7:0]         byte_w, level_w;
  logic [PHASE_W-1:0] phase_nx_w, phase_w;
  logic [2:0]         ones_w;

  afsk_byte_framer #(.PRE_W(PRE_W), .TRL_W(TRL_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sample_tick),
    .start      (start),
    .pre_in     (preamble_len),
    .trl_in     (trailer_len),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .need_byte  (need_w),
    .busy       (busy),
    .start_idle (start_idle_w),
    .fifo_pop   (fifo_pop),
    .load       (load_w),
    .clr_ones   (clr_w),
    .step       (step_w),
    .stop       (stop_w),
    .stuff_en   (stuff_w),
    .byte_now   (byte_w)
  );

  afsk_line_coder #(.SPB(SPB), .MARK_STEP(MARK_STEP), .SPACE_STEP(SPACE_STEP)) u_coder (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_idle (start_idle_w),
    .load       (load_w),
    .clr_ones   (clr_w),
    .step       (step_w),
    .stop       (stop_w),
    .stuff_en   (stuff_w),
    .byte_now   (byte_w),
    .level      (level_w),
    .need_byte  (need_w),
    .phase_nx   (phase_nx_w),
    .phase      (phase_w),
    .ones       (ones_w),
    .tone_space (space_w),
    .sample     (sample)
  );

  afsk_sine_lut u_lut (
    .phase (phase_nx_w),
    .level (level_w)
  );

endmodule

// File: rtl/afsk_mod_checker.sv
module afsk_mod_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       fifo_pop,
  input logic       fifo_empty,
  input logic [7:0] sample,
  input logic       step,
  input logic       stuff_en,
  input logic [2:0] ones,
  input logic [8:0] phase
);

  // R12
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R1
  idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fifo_pop);

  // R7
  ones_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stuff_en) |-> (ones <= 3'd5));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(phase));

  // R3
  phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (phase != $past(phase)));

  // R9
  stop_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sample == 8'd128));

endmodule

bind afsk_hdlc_modulator afsk_mod_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .fifo_pop   (fifo_pop),
  .fifo_empty (fifo_empty),
  .sample     (sample),
  .step       (step_w),
  .stuff_en   (stuff_w),
  .ones       (ones_w),
  .phase      (phase_w)
);

// File: tb/tb_afsk_hdlc_modulator.sv
module tb_afsk_hdlc_modulator;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pre_len = '0;
  logic [7:0] trl_len = '0;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = '0;
  logic       fifo_pop, busy;
  logic [7:0] sample;

  afsk_hdlc_modulator dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .start(start),
    .preamble_len(pre_len), .trailer_len(trl_len),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .busy(busy), .sample(sample)
  );

  // 4-unit period: 250 MHz with 1 ns units
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  byte unsigned q[$];   // stimulus FIFO seen by the design
  byte unsigned mq[$];  // model's own copy of the same FIFO

  int m_busy = 0, m_pre = 0, m_trl = 0, m_stuff = 0, m_ones = 0;
  int m_space = 0, m_phase = 0, m_cnt = 0, m_pos = 8, m_byte = 0, m_sample = 128;

  always @(posedge clk) begin
    if (fifo_pop && q.size() > 0) void'(q.pop_front());
    fifo_empty <= (q.size() == 0);
    fifo_data  <= (q.size() != 0) ? q[0] : 8'h00;
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int quarter(int i);
    longint k, s;
    k = 2 * i + 1;
    s = k * (512 - k);
    return 128 + int'((127 * 16 * s) / (5 * 512 * 512 - 4 * s));
  endfunction

  function automatic int wave(int p);
    int h, v;
    h = p % 256;
    v = quarter(h < 128 ? h : 255 - h);
    return (p >= 256) ? 255 - v : v;
  endfunction

  function automatic void m_halt();
    m_busy = 0;
    m_sample = 128;
  endfunction

  function automatic void model_tick();
    int b;
    if (m_busy == 0) return;
    if (m_cnt == 0) begin
      if (m_pos == 8) begin
        if (mq.size() == 0 && m_trl == 0) begin m_halt(); return; end
        if (m_stuff == 0) m_ones = 0;
        m_stuff = 1;
        if (m_pre > 0)           begin m_pre--; b = 'h7E; end
        else if (mq.size() == 0) begin m_trl--; b = 'h7E; end
        else                     b = mq.pop_front();
        if (b == 'h1B) begin
          if (mq.size() == 0) begin m_halt(); return; end
          b = mq.pop_front();
        end else if (b == 'h7E || b == 'h7F) begin
          m_stuff = 0;
        end
        m_byte = b;
        m_pos = 0;
      end
      if (m_stuff != 0 && m_ones >= 5) begin
        m_ones = 0;
        m_space ^= 1;
      end else begin
        if (((m_byte >> m_pos) & 1) != 0) m_ones++;
        else begin m_ones = 0; m_space ^= 1; end
        m_pos++;
      end
      m_cnt = 8;
    end
    m_phase = (m_phase + (m_space != 0 ? 117 : 64)) % 512;
    m_cnt--;
    m_sample = wave(m_phase);
  endfunction

  task automatic compare_all(string tag);
    check({tag, " busy"}, busy, m_busy);
    check({tag, " sample"}, sample, m_sample);
    check({tag, " R12 fifo depth"}, q.size(), mq.size());
  endtask

  task automatic do_tick(string tag);
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    @(negedge clk);
    model_tick();
    compare_all(tag);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_start(int pre, int trl, string tag);
    @(negedge clk);
    start = 1'b1; pre_len = 8'(pre); trl_len = 8'(trl);
    @(negedge clk);
    start = 1'b0;
    if (m_busy == 0) begin
      m_busy = 1; m_pre = pre; m_trl = trl; m_stuff = 0; m_ones = 0;
      m_space = 0; m_phase = 0; m_cnt = 0; m_pos = 8;
    end else begin
      m_trl = trl;
    end
    compare_all(tag);
  endtask

  task automatic push(int b);
    q.push_back(8'(b));
    mq.push_back(8'(b));
  endtask

  task automatic run_out(string tag);
    for (int g = 0; g < 6000 && m_busy != 0; g++) do_tick(tag);
    check({tag, " R9 ended"}, busy, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset sample", sample, 128);
    check("R1 reset pop", fifo_pop, 0);

    // idle ticks with data waiting must touch nothing
    push('h11);
    @(negedge clk);
    for (int i = 0; i < 3; i++) do_tick("R13 idle");
    check("R13 idle fifo kept", q.size(), 1);
    do_start(0, 0, "R2 start");
    run_out("R5 R6 single byte");

    // basic frame: preamble flags lead with a zero bit, so the first step is space
    push('h00); push('hFF); push('h5A);
    @(negedge clk);
    do_start(2, 1, "R2 start");
    check("R2 busy up", busy, 1);
    check("R2 sample held", sample, 128);
    do_tick("R3 R4 first");
    check("R2 R3 first sample", sample, wave(117));
    run_out("R5 R6 R7 R9 frame");

    // escapes: literal flag, literal escape, abort then stuffed data
    push('h1B); push('h7E); push('h1B); push('h1B); push('h7F); push('h3E); push('hF8);
    @(negedge clk);
    do_start(0, 1, "R10 start");
    run_out("R8 R10 escape");

    // long runs of ones with stuffing across bytes
    push('h1F); push('hFF); push('hFC); push('h7F); push('hFF);
    @(negedge clk);
    do_start(1, 0, "R7 start");
    run_out("R7 R8 runs");

    // escape with nothing behind it stops at once, trailer skipped
    push('hAA); push('h1B);
    @(negedge clk);
    do_start(1, 2, "R10 start");
    run_out("R10 esc at end");
    check("R10 fifo drained", q.size(), 0);

    // trailer reload while busy
    push('hC3); push('h55);
    @(negedge clk);
    do_start(1, 0, "R11 start");
    for (int i = 0; i < 20; i++) do_tick("R11 pre");
    do_start(5, 3, "R11 reload");
    run_out("R11 reload");

    // nothing to send and no flags: first tick ends the frame
    do_start(0, 0, "R9 empty start");
    do_tick("R9 empty");
    check("R9 empty idle", busy, 0);
    check("R9 empty sample", sample, 128);
    for (int i = 0; i < 2; i++) do_tick("R13 after");

    summary();
  end

endmodule